// File: doc/BRIEF.md
# Flash Operation Sequencer Register Block

This block is the host-facing register front end of a serial flash controller. A host on a simple 32-bit register bus sets up a flash address and then starts one flash operation with a single write to a combined control/status word. That word carries the operation code, the transfer length stored as length minus one, and a start bit. The block hands the operation to a flash engine through a level request. The engine reports the outcome with a one-cycle success or failure pulse. The host then sees a sticky completion flag or a sticky error flag, and clears either one by writing a one to it.

Data moves through a 64-byte staging buffer. The host reaches the buffer through a byte-addressable window, and the engine reaches it through its own byte port. Two more registers give the host a way to read parameter-table words: it writes a word index and a table select to one register, then reads the selected word back from another. The table itself lives outside the block.

Register offsets, as 32-bit words: 0x00 control/status, 0x04 flash address, 0x08 parameter index, 0x0C parameter data. The staging buffer window covers 0x40 to 0x7F.

Top module: `flash_seq_regs`

## Requirements
- R1: After reset the control/status word reads 0, the engine request is low, and every staging buffer byte reads 0.
- R2: A control/status write has the start bit 8 set, an operation code in bits 12:10 and a count in bits 21:16, and the block is idle. Such a write raises `eng_req` from the next cycle. It drives `eng_cycle` with the code and `eng_len` with the count. It also clears both flags and reads back busy in bit 2. The supported codes are 0 data read, 1 data write, 2 status read, 3 4 KiB erase and 4 64 KiB erase.
- R3: `eng_addr` shows the flash address register value captured at the start write. Writing the address register while busy changes its readback but not `eng_addr`.
- R4: A start write that arrives while busy is ignored. The operation code, count and address presented to the engine do not change.
- R5: An `eng_done` pulse while busy drops busy and `eng_req` and sets the done flag (bit 0) on the next cycle. An `eng_fail` pulse sets the error flag (bit 1) instead, and failure wins when both pulses come together.
- R6: The done and error flags are write-one-to-clear. A zero written to a flag leaves it unchanged, and the two flags are never set together.
- R7: Erase codes 3 and 4 and the status-read code 2 have no data phase of their own: `eng_len` is 0 whatever count was written. A status read therefore moves exactly one byte.
- R8: A start write with an unsupported code (5 to 7) issues no request and sets the error flag on the next cycle.
- R9: The staging buffer is little-endian. Buffer byte n sits at host address 0x40+n. With `bus_byte` high, a write stores `bus_wdata[7:0]` into that one byte, and a read returns the byte in `bus_rdata[7:0]`. Bytes written by the host are visible on `eng_buf_rdata`, and bytes written by the engine are visible to the host.
- R10: Outside the buffer window, address bits 1:0 are ignored, so every register access is a whole aligned word.
- R11: Bits 11:2 of the parameter index register select the table word and bits 17:16 select the table, and both drive `prm_idx`/`prm_sel`. A read of the parameter data register returns `prm_rdata`. Table word 1 (byte offset 0x04) holds the flash density in bits minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | Byte-wide access to the staging buffer |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data (combinational) |
| eng_req | output | 1 | Operation pending for the engine |
| eng_cycle | output | 3 | Operation code |
| eng_addr | output | FADDR_W | Flash address of the operation |
| eng_len | output | CNT_W | Transfer length minus one |
| eng_done | input | 1 | Success pulse from the engine |
| eng_fail | input | 1 | Failure pulse from the engine |
| eng_buf_we | input | 1 | Engine byte write to the staging buffer |
| eng_buf_idx | input | CNT_W | Engine byte index |
| eng_buf_wdata | input | 8 | Engine write byte |
| eng_buf_rdata | output | 8 | Staging buffer byte at eng_buf_idx |
| prm_sel | output | 2 | Parameter table select |
| prm_idx | output | PRM_IDX_W | Parameter word index |
| prm_rdata | input | 32 | Selected parameter word |

## Verification
A corrupted busy state shows up at the ports within one cycle. Either `eng_req` stays high after a completion pulse, or a second start write changes `eng_cycle` and `eng_len`. A wrong flag state appears at the next control/status read: done and error both set, or a flag still set after a one was written to it. Errors in capture or in the buffer show in value, not timing. `eng_addr` follows a late address write, an erase presents a nonzero length, or a byte lane of the buffer lands in the wrong position on the host read.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam logic [2:0] CYC_RD    = 3'd0;
  localparam logic [2:0] CYC_WR    = 3'd1;
  localparam logic [2:0] CYC_RDSR  = 3'd2;
  localparam logic [2:0] CYC_ER4K  = 3'd3;
  localparam logic [2:0] CYC_ER64K = 3'd4;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_FADDR = 8'h04;
  localparam logic [7:0] OFS_PIDX  = 8'h08;
  localparam logic [7:0] OFS_PDATA = 8'h0C;

  localparam int BIT_DONE = 0;
  localparam int BIT_ERR  = 1;
  localparam int BIT_BUSY = 2;
  localparam int BIT_GO   = 8;
  localparam int LSB_CYC  = 10;
  localparam int LSB_CNT  = 16;
  localparam int LSB_PSEL = 16;

  function automatic logic cyc_has_data(input logic [2:0] c);
    return (c == CYC_RD) || (c == CYC_WR);
  endfunction

  function automatic logic cyc_known(input logic [2:0] c);
    return c <= CYC_ER64K;
  endfunction
endpackage

// File: rtl/fsq_seq.sv
module fsq_seq
  import fsq_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int FADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_wr,
  input  logic               clr_done,
  input  logic               clr_err,
  input  logic [2:0]         cyc_in,
  input  logic [CNT_W-1:0]   cnt_in,
  input  logic [FADDR_W-1:0] addr_in,
  input  logic               eng_done,
  input  logic               eng_fail,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [2:0]         op_cyc,
  output logic [CNT_W-1:0]   op_cnt,
  output logic [FADDR_W-1:0] op_addr
);
  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic [2:0]         cyc_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FADDR_W-1:0] addr_q;
  logic               take, launch_ok, launch_bad, finish;

  always_comb begin
    take       = start_wr && !busy_q;
    launch_ok  = take && cyc_known(cyc_in);
    launch_bad = take && !cyc_known(cyc_in);
    finish     = busy_q && (eng_done || eng_fail);
    cnt_d      = cyc_has_data(cyc_in) ? cnt_in : '0;

    busy_d = busy_q;
    if (launch_ok)   busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;

    done_d = done_q;
    if (take)                      done_d = 1'b0;
    else if (finish && !eng_fail)  done_d = 1'b1;
    else if (clr_done)             done_d = 1'b0;

    err_d = err_q;
    if (launch_ok)                 err_d = 1'b0;
    else if (launch_bad)           err_d = 1'b1;
    else if (finish && eng_fail)   err_d = 1'b1;
    else if (clr_err)              err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      cyc_q  <= cyc_in;
      cnt_q  <= cnt_d;
      addr_q <= addr_in;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
  assign op_cyc  = cyc_q;
  assign op_cnt  = cnt_q;
  assign op_addr = addr_q;

  // R2: while an operation is pending no flag is left over from before
  p_clean_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q && !err_q);
  // R4: a start write while busy leaves the operation untouched
  p_go_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_wr |=> $stable(cyc_q) && $stable(cnt_q) && $stable(addr_q));
  // R5: success completes in one cycle
  p_finish_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && eng_done && !eng_fail |=> !busy_q && done_q);
  // R5: failure wins
  p_finish_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && eng_fail |=> !busy_q && err_q && !done_q);
  // R6: flags are mutually exclusive
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, err_q}));
  // R7: no data length for erase and status read
  p_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !cyc_has_data(cyc_q) |-> cnt_q == '0);
  // R8: unsupported code is rejected
  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !busy_q && !cyc_known(cyc_in) |=> err_q && !busy_q);
endmodule

// File: rtl/fsq_buf.sv
module fsq_buf #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH),
  localparam int WRD_W = CNT_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [WRD_W-1:0] host_word,
  input  logic [3:0]       host_lanes,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             eng_we,
  input  logic [CNT_W-1:0] eng_idx,
  input  logic [7:0]       eng_wdata,
  output logic [7:0]       eng_rdata
);
  logic [7:0] mem_q [DEPTH];

  for (genvar b = 0; b < DEPTH; b++) begin : g_byte
    logic       h_hit, e_hit, en;
    logic [7:0] d;
    always_comb begin
      h_hit = host_we && (host_word == WRD_W'(b / 4)) && host_lanes[b % 4];
      e_hit = eng_we && (eng_idx == CNT_W'(b));
      en    = h_hit || e_hit;
      d     = e_hit ? eng_wdata : host_wdata[8*(b%4) +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[b] <= '0;
      else if (en) mem_q[b] <= d;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign host_rdata[8*k +: 8] = mem_q[{host_word, 2'(k)}];
  end
  assign eng_rdata = mem_q[eng_idx];

  // R9: an engine byte write lands at its index
  p_eng_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> mem_q[$past(eng_idx)] == $past(eng_wdata));
endmodule

// File: rtl/fsq_pwin.sv
module fsq_pwin
  import fsq_pkg::*;
#(
  parameter int PRM_IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wdata,
  output logic [PRM_IDX_W-1:0] prm_idx,
  output logic [1:0]           prm_sel,
  output logic [31:0]          rd_word
);
  logic [PRM_IDX_W-1:0] idx_q;
  logic [1:0]           sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      idx_q <= wdata[2 +: PRM_IDX_W];
      sel_q <= wdata[LSB_PSEL +: 2];
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[2 +: PRM_IDX_W] = idx_q;
    rd_word[LSB_PSEL +: 2]  = sel_q;
  end

  assign prm_idx = idx_q;
  assign prm_sel = sel_q;
endmodule

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import fsq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int FADDR_W   = 32,
  parameter int DEPTH     = 64,
  parameter int PRM_IDX_W = 10,
  localparam int CNT_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_byte,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 eng_req,
  output logic [2:0]           eng_cycle,
  output logic [FADDR_W-1:0]   eng_addr,
  output logic [CNT_W-1:0]     eng_len,
  input  logic                 eng_done,
  input  logic                 eng_fail,
  input  logic                 eng_buf_we,
  input  logic [CNT_W-1:0]     eng_buf_idx,
  input  logic [7:0]           eng_buf_wdata,
  output logic [7:0]           eng_buf_rdata,
  output logic [1:0]           prm_sel,
  output logic [PRM_IDX_W-1:0] prm_idx,
  input  logic [31:0]          prm_rdata
);
  localparam int WRD_W = CNT_W - 2;

  logic                buf_hit, wr, rd_sel;
  logic [ADDR_W-1:0]   wa;
  logic                hit_ctrl, hit_faddr, hit_pidx, hit_pdata;
  logic [3:0]          lanes;
  logic [31:0]         buf_wdata, buf_rdata, pidx_word, ctrl_word;
  logic [7:0]          buf_byte;
  logic [FADDR_W-1:0]  faddr_q;
  logic                busy, done, err;
  logic [2:0]          op_cyc;
  logic [CNT_W-1:0]    op_cnt;

  always_comb begin
    wa        = {bus_addr[ADDR_W-1:2], 2'b00};
    buf_hit   = bus_addr[ADDR_W-1:CNT_W] == (ADDR_W-CNT_W)'(1);
    hit_ctrl  = !buf_hit && (wa == ADDR_W'(OFS_CTRL));
    hit_faddr = !buf_hit && (wa == ADDR_W'(OFS_FADDR));
    hit_pidx  = !buf_hit && (wa == ADDR_W'(OFS_PIDX));
    hit_pdata = !buf_hit && (wa == ADDR_W'(OFS_PDATA));
    wr        = bus_sel && bus_wr;
    rd_sel    = bus_sel && !bus_wr;
    lanes     = bus_byte ? (4'b0001 << bus_addr[1:0]) : 4'b1111;
    buf_wdata = bus_byte ? {4{bus_wdata[7:0]}} : bus_wdata;
    buf_byte  = buf_rdata[8*bus_addr[1:0] +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                faddr_q <= '0;
    else if (wr && hit_faddr)  faddr_q <= bus_wdata[FADDR_W-1:0];
  end

  fsq_seq #(.CNT_W(CNT_W), .FADDR_W(FADDR_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (wr && hit_ctrl && bus_wdata[BIT_GO]),
    .clr_done (wr && hit_ctrl && bus_wdata[BIT_DONE]),
    .clr_err  (wr && hit_ctrl && bus_wdata[BIT_ERR]),
    .cyc_in   (bus_wdata[LSB_CYC +: 3]),
    .cnt_in   (bus_wdata[LSB_CNT +: CNT_W]),
    .addr_in  (faddr_q),
    .eng_done (eng_done),
    .eng_fail (eng_fail),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .op_cyc   (op_cyc),
    .op_cnt   (op_cnt),
    .op_addr  (eng_addr)
  );

  fsq_buf #(.DEPTH(DEPTH)) i_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (wr && buf_hit),
    .host_word  (bus_addr[CNT_W-1:2]),
    .host_lanes (lanes),
    .host_wdata (buf_wdata),
    .host_rdata (buf_rdata),
    .eng_we     (eng_buf_we),
    .eng_idx    (eng_buf_idx),
    .eng_wdata  (eng_buf_wdata),
    .eng_rdata  (eng_buf_rdata)
  );

  fsq_pwin #(.PRM_IDX_W(PRM_IDX_W)) i_pwin (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr && hit_pidx),
    .wdata   (bus_wdata),
    .prm_idx (prm_idx),
    .prm_sel (prm_sel),
    .rd_word (pidx_word)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_DONE] = done;
    ctrl_word[BIT_ERR]  = err;
    ctrl_word[BIT_BUSY] = busy;
    ctrl_word[LSB_CYC +: 3]     = op_cyc;
    ctrl_word[LSB_CNT +: CNT_W] = op_cnt;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_sel) begin
      if (buf_hit)        bus_rdata = bus_byte ? {24'h0, buf_byte} : buf_rdata;
      else if (hit_ctrl)  bus_rdata = ctrl_word;
      else if (hit_faddr) bus_rdata = 32'(faddr_q);
      else if (hit_pidx)  bus_rdata = pidx_word;
      else if (hit_pdata) bus_rdata = prm_rdata;
    end
  end

  assign eng_req   = busy;
  assign eng_cycle = op_cyc;
  assign eng_len   = op_cnt;

  // R3: the presented address holds while a request is pending
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && $past(eng_req) |-> $stable(eng_addr));
  // R2: a request starts only from a start write
  p_req_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_req) |-> $past(wr && hit_ctrl && bus_wdata[BIT_GO]));
endmodule

// File: tb/test_flash_seq_regs.sv
module test_flash_seq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0, bus_byte = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_req;
  logic [2:0]  eng_cycle;
  logic [31:0] eng_addr;
  logic [5:0]  eng_len;
  logic        eng_done = 0, eng_fail = 0, eng_buf_we = 0;
  logic [5:0]  eng_buf_idx = '0;
  logic [7:0]  eng_buf_wdata = '0;
  logic [7:0]  eng_buf_rdata;
  logic [1:0]  prm_sel;
  logic [9:0]  prm_idx;
  logic [31:0] prm_rdata;

  localparam logic [31:0] DENSITY = 32'h00FF_FFFF;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign prm_rdata = (prm_sel == 2'd1 && prm_idx == 10'd1) ? DENSITY
                                                            : {20'h0, prm_sel, prm_idx};

  flash_seq_regs i_flash_seq_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_req(eng_req), .eng_cycle(eng_cycle), .eng_addr(eng_addr), .eng_len(eng_len),
    .eng_done(eng_done), .eng_fail(eng_fail), .eng_buf_we(eng_buf_we),
    .eng_buf_idx(eng_buf_idx), .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata),
    .prm_sel(prm_sel), .prm_idx(prm_idx), .prm_rdata(prm_rdata)
  );

  typedef struct packed {
    logic [2:0]  cyc;
    logic [5:0]  cnt;
    logic [31:0] addr;
    logic        fail;
    logic [5:0]  exp_len;
    logic        launch;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 6'd15, 32'h0000_1000, 1'b0, 6'd15, 1'b1},
    '{3'd1, 6'd63, 32'h2000_0100, 1'b0, 6'd63, 1'b1},
    '{3'd3, 6'd7,  32'h0000_3000, 1'b0, 6'd0,  1'b1},
    '{3'd4, 6'd63, 32'h0001_0000, 1'b1, 6'd0,  1'b1},
    '{3'd2, 6'd9,  32'h0000_0000, 1'b0, 6'd0,  1'b1},
    '{3'd7, 6'd3,  32'h0000_0044, 1'b0, 6'd0,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d, input logic by);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_byte = by; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_byte = 0;
  endtask

  task automatic br(input logic [11:0] a, input logic by, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_byte = by; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_byte = 0;
  endtask

  task automatic finish_op(input logic fail);
    @(negedge clk);
    eng_done = !fail; eng_fail = fail;
    @(negedge clk);
    eng_done = 0; eng_fail = 0;
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] c, input logic [5:0] n);
    return (32'(n) << 16) | (32'(c) << 10) | 32'h0000_0103;
  endfunction

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    br(12'h000, 0, r); chk("R1 ctrl", r, 0);
    chk("R1 req", 32'(eng_req), 0);
    br(12'h07C, 0, r); chk("R1 buffer", r, 0);

    // vector walk: R2 R5 R7 R8
    foreach (VEC[i]) begin
      bw(12'h004, VEC[i].addr, 0);
      bw(12'h000, ctl(VEC[i].cyc, VEC[i].cnt), 0);
      chk("R2/R8 req", 32'(eng_req), 32'(VEC[i].launch));
      if (VEC[i].launch) begin
        chk("R2 cycle", 32'(eng_cycle), 32'(VEC[i].cyc));
        chk("R2/R7 len", 32'(eng_len), 32'(VEC[i].exp_len));
        chk("R3 addr", eng_addr, VEC[i].addr);
        br(12'h000, 0, r); chk("R2 busy", 32'(r[2:0]), 32'h4);
        finish_op(VEC[i].fail);
        chk("R5 req drop", 32'(eng_req), 0);
        br(12'h000, 0, r);
        chk("R5 flags", 32'(r[2:0]), VEC[i].fail ? 32'h2 : 32'h1);
      end else begin
        br(12'h000, 0, r); chk("R8 error flag", 32'(r[2:0]), 32'h2);
      end
    end

    // R6: zero write keeps, one clears
    bw(12'h000, 32'h0, 0);
    br(12'h000, 0, r); chk("R6 err kept", 32'(r[1]), 1);
    bw(12'h000, 32'h2, 0);
    br(12'h000, 0, r); chk("R6 err cleared", 32'(r[1:0]), 0);

    // R3 and R4: hold during busy
    bw(12'h004, 32'hAAAA_0000, 0);
    bw(12'h000, ctl(3'd0, 6'd5), 0);
    bw(12'h004, 32'hBBBB_0000, 0);
    chk("R3 addr held", eng_addr, 32'hAAAA_0000);
    br(12'h004, 0, r); chk("R3 reg readback", r, 32'hBBBB_0000);
    bw(12'h000, ctl(3'd1, 6'd3), 0);
    chk("R4 cycle held", 32'(eng_cycle), 0);
    chk("R4 len held", 32'(eng_len), 5);
    chk("R4 addr held", eng_addr, 32'hAAAA_0000);
    finish_op(1'b0);
    br(12'h000, 0, r); chk("R4 single completion", 32'(r[2:0]), 32'h1);
    bw(12'h000, 32'h1, 0);
    br(12'h000, 0, r); chk("R6 done cleared", 32'(r[1:0]), 0);

    // R5: simultaneous pulses, failure wins
    bw(12'h000, ctl(3'd0, 6'd0), 0);
    @(negedge clk); eng_done = 1; eng_fail = 1;
    @(negedge clk); eng_done = 0; eng_fail = 0;
    br(12'h000, 0, r); chk("R5 fail wins", 32'(r[2:0]), 32'h2);

    // R9: staging buffer
    bw(12'h040, 32'hA1B2_C3D4, 0);
    bw(12'h045, 32'h0000_005E, 1);
    br(12'h042, 1, r); chk("R9 byte read", r, 32'h0000_00B2);
    br(12'h044, 0, r); chk("R9 byte write lane", r, 32'h0000_5E00);
    eng_buf_idx = 6'd5; #1 chk("R9 engine sees host", 32'(eng_buf_rdata), 32'h5E);
    @(negedge clk); eng_buf_we = 1; eng_buf_idx = 6'd10; eng_buf_wdata = 8'h77;
    @(negedge clk); eng_buf_we = 0;
    br(12'h04A, 1, r); chk("R9 host sees engine byte", r, 32'h77);
    br(12'h048, 0, r); chk("R9 host sees engine word", r, 32'h0077_0000);

    // R10: unaligned register access
    bw(12'h007, 32'h1234_5678, 0);
    br(12'h004, 0, r); chk("R10 aligned write", r, 32'h1234_5678);
    br(12'h005, 0, r); chk("R10 aligned read", r, 32'h1234_5678);

    // R11: parameter window, density word
    bw(12'h008, 32'h0001_0004, 0);
    chk("R11 idx", 32'(prm_idx), 1);
    chk("R11 sel", 32'(prm_sel), 1);
    br(12'h00C, 0, r); chk("R11 density", r, DENSITY);
    br(12'h00B, 0, r); chk("R11 index readback", r, 32'h0001_0004);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule